// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block owns the fetch address of a small in-order core with 16-bit instructions. Every cycle it hands the fetch unit one address. It watches the branch request that the decode stage presents for the instruction now in decode, and moves the fetch address to the branch destination when the branch is taken. The destination comes either from a register value supplied with the request, or from the address of the branching instruction plus a signed halfword displacement.

Two kinds of unconditional and conditional transfer are handled. A delayed branch lets the instruction that follows it run as a delay slot before the destination runs. The sequencer flags that slot instruction to decode, and it captures the destination during the branch's own decode cycle. A later write to the source register by the slot therefore cannot move the branch. An immediate branch squashes the instruction that was already fetched, through a one-cycle kill flag. A conditional branch is taken only when the status flag matches the sense that the request asks for.

A branch that decode offers while the slot flag is high is refused, and an illegal-slot flag is raised. A stall input freezes the whole sequencer. The stall is the only back-pressure: while it is high, the decode-side request is not consumed and the fetch address is held. All pins are plain control and status lines with no handshake.

Top module: `dslot_pc_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, fetch_pc equals reset_vec, dec_pc and tgt_hold are zero, and slot_active, kill, illegal_slot and tgt_capture are low. No request is acted on until one fetch has advanced into decode.
- R2: In a non-stalled cycle with no taken branch, fetch_pc increases by 2 at the next clock edge, and dec_pc takes the old fetch_pc.
- R3: A taken branch with br_delayed=1 sets fetch_pc to the destination at the next edge. It raises slot_active for exactly one advancing cycle, in which dec_pc is the branch address plus 2, and it leaves kill low.
- R4: A taken delayed branch pulses tgt_capture in its decode cycle, and tgt_hold holds that destination from the next edge. A value on br_reg_val offered later, including during the slot, changes neither the fetch path nor tgt_hold.
- R5: A taken branch with br_delayed=0 sets fetch_pc to the destination at the next edge. It raises kill for exactly one advancing cycle, and slot_active stays low.
- R6: With br_cond=1 the branch is taken only when t_flag equals br_sense. When it is not taken, the cycle behaves as in R2, with no slot, no kill and no capture. With br_cond=0 the branch is always taken.
- R7: With br_use_reg=0 the destination is dec_pc plus twice br_disp, where br_disp is sign-extended and arithmetic wraps at the address width. With br_use_reg=1 the destination is br_reg_val.
- R8: A request offered while slot_active is high, and not stalled, raises illegal_slot in that same cycle. It causes no redirect (fetch_pc advances by 2), and no slot follows it.
- R9: A request offered while kill is high belongs to a squashed instruction. It is ignored: no redirect, no slot, no kill, no illegal flag.
- R10: While stall is high, fetch_pc, dec_pc, slot_active, kill and tgt_hold keep their values, no request is consumed, and illegal_slot and tgt_capture stay low. A pending slot resumes after the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_vec | input | AW | Fetch address loaded by reset |
| stall | input | 1 | Freezes all sequencer state |
| br_valid | input | 1 | Instruction in decode is a branch |
| br_delayed | input | 1 | 1 = delay slot follows, 0 = immediate transfer |
| br_use_reg | input | 1 | 1 = destination from br_reg_val, 0 = PC-relative |
| br_cond | input | 1 | Branch depends on t_flag |
| br_sense | input | 1 | t_flag value that makes a conditional branch taken |
| t_flag | input | 1 | Status flag set by compares |
| br_disp | input | DW | Signed halfword displacement |
| br_reg_val | input | AW | Register-sourced destination |
| fetch_pc | output | AW | Address being fetched this cycle |
| dec_pc | output | AW | Address of the instruction in decode |
| slot_active | output | 1 | Instruction in decode is a delay slot |
| kill | output | 1 | Instruction in decode is squashed |
| illegal_slot | output | 1 | A branch was offered inside a delay slot |
| tgt_capture | output | 1 | Destination of a delayed branch latched this cycle |
| tgt_hold | output | AW | Latched destination of the last delayed branch |

## Verification
A stall and a branch request can land in the same cycle as a pending delay slot. The two functions that then collide are the freeze and the illegal-slot refusal. The bench provokes this by raising stall in the slot cycle while it keeps a branch offered, and by changing br_reg_val at the same time. It judges the outcome against its own arithmetic model. Under the stall, illegal_slot must stay low and slot_active must persist. Once the stall is released, the flag must rise, the fetch must advance by 2, and tgt_hold must still show the destination captured in the branch cycle.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ  = 2'd0,
    NXT_TGT  = 2'd1,
    NXT_HOLD = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/dslot_tgt_calc.sv
module dslot_tgt_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] reg_val,
  input  logic [DW-1:0] disp,
  input  logic          use_reg,
  input  logic          cond,
  input  logic          sense,
  input  logic          t_flag,
  output logic [AW-1:0] target,
  output logic          cond_ok
);
  localparam int EXT = AW - DW - 1;

  logic [AW-1:0] disp_bytes;

  // sign-extended halfword displacement converted to bytes
  assign disp_bytes = {{EXT{disp[DW-1]}}, disp, 1'b0};
  assign target     = use_reg ? reg_val : dec_pc + disp_bytes;
  assign cond_ok    = !cond || (t_flag == sense);

  initial begin
    assert_width_fit_R7: assert (AW > DW + 1)
      else $error("address width too small for displacement");
  end
endmodule

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
  import dslot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stall,
  input  logic     req_v,
  input  logic     req_dly,
  input  logic     cond_ok,
  output nxt_sel_e nxt_sel,
  output logic     slot_q,
  output logic     kill_q,
  output logic     illegal,
  output logic     capture
);
  logic dvalid_q;
  logic live;
  logic taken;

  // a request counts only for a real, unsquashed, unstalled decode slot
  assign live    = req_v && dvalid_q && !kill_q && !stall;
  assign illegal = live && slot_q;
  assign taken   = live && !slot_q && cond_ok;
  assign capture = taken && req_dly;

  always_comb begin
    if (stall)      nxt_sel = NXT_HOLD;
    else if (taken) nxt_sel = NXT_TGT;
    else            nxt_sel = NXT_SEQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvalid_q <= 1'b0;
      slot_q   <= 1'b0;
      kill_q   <= 1'b0;
    end else if (!stall) begin
      dvalid_q <= 1'b1;
      slot_q   <= capture;
      kill_q   <= taken && !req_dly;
    end
  end

  assert_slot_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q && !stall) |=> !slot_q);

  assert_kill_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && !stall) |=> !kill_q);

  assert_slot_kill_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_q && kill_q));

  assert_no_nested_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !slot_q);

  assert_killed_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && !stall) |=> (!slot_q && !kill_q));

  assert_stall_hold_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(slot_q) && $stable(kill_q)));
endmodule

// File: rtl/dslot_pc_regs.sv
module dslot_pc_regs
  import dslot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_vec,
  input  nxt_sel_e      nxt_sel,
  input  logic [AW-1:0] target,
  input  logic          capture,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] dpc_q,
  output logic [AW-1:0] tgt_q
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= reset_vec;
      dpc_q <= '0;
      tgt_q <= '0;
    end else begin
      case (nxt_sel)
        NXT_SEQ: begin
          pc_q  <= pc_q + STEP;
          dpc_q <= pc_q;
        end
        NXT_TGT: begin
          pc_q  <= target;
          dpc_q <= pc_q;
        end
        default: ;
      endcase
      if (capture) tgt_q <= target;
    end
  end

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_sel == NXT_SEQ) |=> (pc_q == $past(pc_q) + STEP && dpc_q == $past(pc_q)));

  assert_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_sel == NXT_TGT) |=> (pc_q == $past(target)));

  assert_capture_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (tgt_q == pc_q));

  assert_stall_hold_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_sel == NXT_HOLD) |=> ($stable(pc_q) && $stable(dpc_q) && $stable(tgt_q)));
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dslot_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_vec,
  input  logic          stall,
  input  logic          br_valid,
  input  logic          br_delayed,
  input  logic          br_use_reg,
  input  logic          br_cond,
  input  logic          br_sense,
  input  logic          t_flag,
  input  logic [DW-1:0] br_disp,
  input  logic [AW-1:0] br_reg_val,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] dec_pc,
  output logic          slot_active,
  output logic          kill,
  output logic          illegal_slot,
  output logic          tgt_capture,
  output logic [AW-1:0] tgt_hold
);
  nxt_sel_e      nxt_sel;
  logic [AW-1:0] target;
  logic          cond_ok;

  dslot_tgt_calc #(.AW(AW), .DW(DW)) u_tgt (
    .dec_pc  (dec_pc),
    .reg_val (br_reg_val),
    .disp    (br_disp),
    .use_reg (br_use_reg),
    .cond    (br_cond),
    .sense   (br_sense),
    .t_flag  (t_flag),
    .target  (target),
    .cond_ok (cond_ok)
  );

  dslot_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .req_v   (br_valid),
    .req_dly (br_delayed),
    .cond_ok (cond_ok),
    .nxt_sel (nxt_sel),
    .slot_q  (slot_active),
    .kill_q  (kill),
    .illegal (illegal_slot),
    .capture (tgt_capture)
  );

  dslot_pc_regs #(.AW(AW), .INSN_BYTES(2)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_vec (reset_vec),
    .nxt_sel   (nxt_sel),
    .target    (target),
    .capture   (tgt_capture),
    .pc_q      (fetch_pc),
    .dpc_q     (dec_pc),
    .tgt_q     (tgt_hold)
  );

  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!illegal_slot && !tgt_capture));

  assert_illegal_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_slot |=> (fetch_pc == $past(fetch_pc) + AW'(2)));
endmodule

// File: tb/dslot_pc_seq_tb_top.sv
module dslot_pc_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MAX_CYC = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reset_vec = 16'h0100;
  logic          stall = 1'b0;
  logic          br_valid = 1'b0, br_delayed = 1'b0, br_use_reg = 1'b0;
  logic          br_cond = 1'b0, br_sense = 1'b0, t_flag = 1'b0;
  logic [DW-1:0] br_disp = '0;
  logic [AW-1:0] br_reg_val = '0;
  logic [AW-1:0] fetch_pc, dec_pc, tgt_hold;
  logic          slot_active, kill, illegal_slot, tgt_capture;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [AW-1:0] m_pc, m_dpc, m_tgt;
  logic          m_slot, m_kill, m_dvalid;

  always #5 clk = ~clk;

  dslot_pc_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec), .stall(stall),
    .br_valid(br_valid), .br_delayed(br_delayed), .br_use_reg(br_use_reg),
    .br_cond(br_cond), .br_sense(br_sense), .t_flag(t_flag),
    .br_disp(br_disp), .br_reg_val(br_reg_val),
    .fetch_pc(fetch_pc), .dec_pc(dec_pc), .slot_active(slot_active),
    .kill(kill), .illegal_slot(illegal_slot), .tgt_capture(tgt_capture),
    .tgt_hold(tgt_hold)
  );

  task automatic chk(input string tag, input string what,
                     input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic st, input logic bv, input logic dly,
                      input logic ureg, input logic cnd, input logic sns,
                      input logic tf, input logic [DW-1:0] d,
                      input logic [AW-1:0] rv);
    logic live, ill, taken, cap;
    logic [AW-1:0] dest, disp_b;
    string tg;
    stall = st; br_valid = bv; br_delayed = dly; br_use_reg = ureg;
    br_cond = cnd; br_sense = sns; t_flag = tf; br_disp = d; br_reg_val = rv;
    #2;
    disp_b = AW'($signed(d)) << 1;
    dest   = ureg ? rv : m_dpc + disp_b;
    live   = bv && m_dvalid && !m_kill && !st;
    ill    = live && m_slot;
    taken  = live && !m_slot && (!cnd || (tf == sns));
    cap    = taken && dly;
    chk("R8", "illegal_slot", AW'(illegal_slot), AW'(ill));
    chk("R4", "tgt_capture", AW'(tgt_capture), AW'(cap));
    if (st) tg = "R10";
    else if (ill) tg = "R8";
    else if (bv && m_dvalid && m_kill) tg = "R9";
    else if (taken && dly) tg = "R3/R7";
    else if (taken) tg = "R5/R7";
    else if (bv && m_dvalid) tg = "R6";
    else tg = "R2";
    if (!st) begin
      m_dvalid = 1'b1;
      m_dpc    = m_pc;
      m_pc     = taken ? dest : m_pc + AW'(2);
      m_slot   = cap;
      m_kill   = taken && !dly;
      if (cap) m_tgt = dest;
    end
    @(posedge clk);
    #1;
    chk(tg, "fetch_pc", fetch_pc, m_pc);
    chk(st ? "R10" : "R2", "dec_pc", dec_pc, m_dpc);
    chk(st ? "R10" : "R3", "slot_active", AW'(slot_active), AW'(m_slot));
    chk(st ? "R10" : "R5", "kill", AW'(kill), AW'(m_kill));
    chk(st ? "R10" : "R4", "tgt_hold", tgt_hold, m_tgt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #(MAX_CYC * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] disps [4];
    disps[0] = 8'h00; disps[1] = 8'h7F; disps[2] = 8'h80; disps[3] = 8'hFE;
    repeat (3) @(posedge clk);
    #1;
    // R1: values held in reset
    chk("R1", "fetch_pc in reset", fetch_pc, reset_vec);
    chk("R1", "slot in reset", AW'(slot_active), '0);
    rst_n = 1'b1;
    #1;
    chk("R1", "fetch_pc after reset", fetch_pc, reset_vec);
    chk("R1", "dec_pc after reset", dec_pc, '0);
    chk("R1", "tgt_hold after reset", tgt_hold, '0);
    chk("R1", "kill after reset", AW'(kill), '0);
    m_pc = reset_vec; m_dpc = '0; m_tgt = '0;
    m_slot = 1'b0; m_kill = 1'b0; m_dvalid = 1'b0;
    // R1: request before anything reached decode is ignored
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 16'h4000);

    // sweep over every branch flavour and a set of displacements
    for (int k = 0; k < 128; k++) begin
      logic dly, ureg, cnd, sns, tf, st2;
      logic [AW-1:0] rv1, rv2;
      dly = k[0]; ureg = k[1]; cnd = k[2]; sns = k[3]; tf = k[4];
      st2 = k[0] ^ k[2];
      rv1 = 16'h2000 + AW'(k * 6);
      rv2 = 16'h7000 - AW'(k * 4);
      idle(2);
      step(1'b0, 1'b1, dly, ureg, cnd, sns, tf, disps[k[6:5]], rv1);
      // same-cycle collision: stall while a branch is offered in slot/kill
      if (st2) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10, rv2);
      // branch in slot (R8) or in squashed instruction (R9), new reg value (R4)
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10, rv2);
      idle(2);
    end

    // pseudo-random stress
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0] == 2'b00, r[4:2] < 3'd3, r[5], r[6], r[7], r[8], r[9],
           r[17:10], {r[31:18], 1'b0, 1'b0} ^ AW'(i * 2));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule